// File: doc/BRIEF.md
# Interrupt Pending and Gating Unit

This block keeps the interrupt-pending state of one processor thread as an eight-bit vector, one bit per interrupt line. Software or hardware sources post and clear individual lines by number, or wipe every line at once. A comparator on the core timer's count and compare values sets the pending bit that a run-time select field chooses. A match while the count is zero does not count.

From the pending vector and the thread's status fields, the block produces a registered interrupt request. The request is taken only when interrupts are globally enabled, the thread is neither at error level nor at exception level, and at least one pending line is unmasked. A separate any-pending flag reports whether anything is pending at all, whatever the enable and mask settings. A line number outside the legal range never touches the vector. Instead it raises a one-cycle error flag.

Top module: `irq_pending_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pending`, `irq_req` and `line_err` become zero at that edge.
- R2: A post with legal line n (0 to 7) sets `pending[n]` at the next edge and leaves every other bit unchanged.
- R3: A clear with legal line n clears `pending[n]` at the next edge and leaves every other bit unchanged.
- R4: A clear-all request makes `pending` all zero at the next edge, unless a post or a timer set lands in the same cycle.
- R5: A post or clear whose 4-bit line number is 8 to 15 changes no pending bit. `line_err` is high for the cycle after it and low after any cycle with no illegal request.
- R6: When `tmr_compare` equals `tmr_count` and `tmr_count` is nonzero, `pending[tmr_sel]` is set at the next edge. `tmr_sel` is a 3-bit line index.
- R7: When `tmr_count` is zero, equal count and compare set no pending bit.
- R8: A post and a clear of the same line in one cycle leave the bit set. A timer set of a bit overrides a clear or a clear-all of that bit in the same cycle.
- R9: `irq_req` is registered. After each edge it equals (gie AND NOT err_lvl AND NOT exc_lvl in the previous cycle) AND (the previous cycle's mask ANDed with the new `pending` is nonzero).
- R10: `any_pend` is combinational. It is high when `pending` is nonzero or a timer match (per R6) is present in the current cycle, regardless of `gie`, `err_lvl`, `exc_lvl` and `mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_vld | input | 1 | Post request strobe |
| post_line | input | 4 | Line number to post |
| clr_vld | input | 1 | Clear request strobe |
| clr_line | input | 4 | Line number to clear |
| clr_all | input | 1 | Clear every pending line |
| gie | input | 1 | Global interrupt enable |
| err_lvl | input | 1 | Error level, blocks requests when high |
| exc_lvl | input | 1 | Exception level, blocks requests when high |
| mask | input | 8 | Per-line interrupt mask, 1 = unmasked |
| tmr_count | input | 32 | Core timer count value |
| tmr_compare | input | 32 | Core timer compare value |
| tmr_sel | input | 3 | Pending line driven by the timer |
| pending | output | 8 | Pending vector |
| irq_req | output | 1 | Registered interrupt request |
| any_pend | output | 1 | Something pending or a timer match present |
| line_err | output | 1 | Illegal line number seen last cycle |

## Verification
`pending`, `line_err` and `irq_req` are due one edge after the stimulus. The bench drives inputs on the falling edge and reads these three just after the next rising edge. `any_pend` has no register on its path, so the bench reads it before that rising edge, while the stimulus is still applied. A running model of the vector is advanced only after each edge's checks, so every expected value refers to the same cycle as the sample it is compared with.

// File: rtl/irq_pkg.sv
// Package: shared types for the interrupt pending and gating unit.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_pkg;
    // Fields of the thread status word that gate interrupt delivery.
    typedef struct packed {
        logic gie;
        logic err_lvl;
        logic exc_lvl;
    } irq_status_t;
endpackage

// File: rtl/irq_line_decode.sv
// Module: irq_line_decode
// Turns a line-number request into a one-hot bit vector.
// Flags an out-of-range line instead of decoding it.
// Assumes: IDX_W bits can hold values at and above LINES.
module irq_line_decode #(
    parameter int unsigned LINES = 8,
    parameter int unsigned IDX_W = 4
) (
    input  logic             req,
    input  logic [IDX_W-1:0] line,
    output logic [LINES-1:0] hot,
    output logic             bad
);
    // One comparator per line; out-of-range numbers match none of them.
    for (genvar i = 0; i < LINES; i++) begin : g_dec
        assign hot[i] = req && (line == IDX_W'(i));
    end

    // Illegal line detection.
    always_comb begin
        bad = req && (32'(line) >= 32'(LINES));
    end
endmodule

// File: rtl/irq_timer_match.sv
// Module: irq_timer_match
// Compares timer count against compare value.
// On a match with a nonzero count, drives a one-hot set vector for the selected line.
// Assumes: sel is always below LINES (LINES a power of two).
module irq_timer_match #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned LINES = 8,
    parameter int unsigned SEL_W = 3
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] compare,
    input  logic [SEL_W-1:0] sel,
    output logic             hit,
    output logic [LINES-1:0] set_vec
);
    // Match qualifier: equality with a nonzero count.
    always_comb begin
        hit = (count == compare) && (count != '0);
    end

    // Route the match to the chosen line.
    for (genvar i = 0; i < LINES; i++) begin : g_route
        assign set_vec[i] = hit && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/irq_pending_reg.sv
// Module: irq_pending_reg
// Holds the pending vector.
// Within a cycle, clears are applied first and sets last, so sets win.
// Assumes: set and clear vectors are already legal one-hot or zero.
module irq_pending_reg #(
    parameter int unsigned LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] clr_vec,
    input  logic             clr_all,
    input  logic [LINES-1:0] set_vec,
    output logic [LINES-1:0] pend_q,
    output logic [LINES-1:0] pend_d
);
    // Next-state: drop cleared bits, then OR in every set source.
    always_comb begin
        pend_d = clr_all ? '0 : (pend_q & ~clr_vec);
        pend_d = pend_d | set_vec;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/irq_gate.sv
// Module: irq_gate
// Registers the interrupt request from the status fields and the unmasked next-state pending bits.
// Assumes: pend_next is the value the pending register loads at this edge.
module irq_gate
    import irq_pkg::*;
#(
    parameter int unsigned LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  irq_status_t      status,
    input  logic [LINES-1:0] mask,
    input  logic [LINES-1:0] pend_next,
    output logic             irq_q
);
    logic open_w;

    // Delivery window: enabled and at neither error nor exception level.
    always_comb begin
        open_w = status.gie && !status.err_lvl && !status.exc_lvl;
    end

    // Request register.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= open_w && ((mask & pend_next) != '0);
    end
endmodule

// File: rtl/irq_pending_gate.sv
// Module: irq_pending_gate (top)
// Interrupt pending state and request gating for one thread.
// Assumes: LINES is a power of two, and LINE_W is wide enough to carry out-of-range numbers.
module irq_pending_gate
    import irq_pkg::*;
#(
    parameter int unsigned LINES  = 8,
    parameter int unsigned LINE_W = 4,
    parameter int unsigned CNT_W  = 32,
    localparam int unsigned SEL_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_vld,
    input  logic [LINE_W-1:0] post_line,
    input  logic              clr_vld,
    input  logic [LINE_W-1:0] clr_line,
    input  logic              clr_all,
    input  logic              gie,
    input  logic              err_lvl,
    input  logic              exc_lvl,
    input  logic [LINES-1:0]  mask,
    input  logic [CNT_W-1:0]  tmr_count,
    input  logic [CNT_W-1:0]  tmr_compare,
    input  logic [SEL_W-1:0]  tmr_sel,
    output logic [LINES-1:0]  pending,
    output logic              irq_req,
    output logic              any_pend,
    output logic              line_err
);
    logic [LINES-1:0] post_hot, clr_hot, tmr_hot, pend_q, pend_d;
    logic             post_bad, clr_bad, tmr_hit, err_q;
    irq_status_t      status_w;

    irq_line_decode #(.LINES(LINES), .IDX_W(LINE_W)) u_post_dec (
        .req(post_vld), .line(post_line), .hot(post_hot), .bad(post_bad));

    irq_line_decode #(.LINES(LINES), .IDX_W(LINE_W)) u_clr_dec (
        .req(clr_vld), .line(clr_line), .hot(clr_hot), .bad(clr_bad));

    irq_timer_match #(.CNT_W(CNT_W), .LINES(LINES), .SEL_W(SEL_W)) u_tmr (
        .count(tmr_count), .compare(tmr_compare), .sel(tmr_sel),
        .hit(tmr_hit), .set_vec(tmr_hot));

    irq_pending_reg #(.LINES(LINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .clr_vec(clr_hot), .clr_all(clr_all),
        .set_vec(post_hot | tmr_hot), .pend_q(pend_q), .pend_d(pend_d));

    // Pack the status fields for the gate.
    always_comb begin
        status_w.gie     = gie;
        status_w.err_lvl = err_lvl;
        status_w.exc_lvl = exc_lvl;
    end

    irq_gate #(.LINES(LINES)) u_gate (
        .clk(clk), .rst_n(rst_n), .status(status_w), .mask(mask),
        .pend_next(pend_d), .irq_q(irq_req));

    // Illegal line flag, one cycle after the offending request.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= post_bad || clr_bad;
    end

    // Output assignments; any_pend includes a same-cycle timer match.
    always_comb begin
        pending  = pend_q;
        line_err = err_q;
        any_pend = (pend_q != '0) || tmr_hit;
    end
endmodule

// File: rtl/irq_pending_chk.sv
// Module: irq_pending_chk
// Property checks on the ports of irq_pending_gate, attached by bind.
module irq_pending_chk #(
    parameter int unsigned LINES  = 8,
    parameter int unsigned LINE_W = 4,
    parameter int unsigned CNT_W  = 32,
    localparam int unsigned SEL_W = $clog2(LINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              post_vld,
    input logic [LINE_W-1:0] post_line,
    input logic              clr_vld,
    input logic [LINE_W-1:0] clr_line,
    input logic              clr_all,
    input logic              gie,
    input logic              err_lvl,
    input logic              exc_lvl,
    input logic [LINES-1:0]  mask,
    input logic [CNT_W-1:0]  tmr_count,
    input logic [CNT_W-1:0]  tmr_compare,
    input logic [SEL_W-1:0]  tmr_sel,
    input logic [LINES-1:0]  pending,
    input logic              irq_req,
    input logic              any_pend,
    input logic              line_err
);
    logic hit_c;
    assign hit_c = (tmr_count == tmr_compare) && (tmr_count != '0);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pending == '0 && !irq_req && !line_err));

    a_r2_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && 32'(post_line) < 32'(LINES))
        |=> pending[$past(post_line[SEL_W-1:0])]);

    a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !post_vld && !hit_c) |=> pending == '0);

    a_r5_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && 32'(post_line) >= 32'(LINES) && !clr_vld && !clr_all && !hit_c)
        |=> (pending == $past(pending) && line_err));

    a_r6_timer_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit_c |=> pending[$past(tmr_sel)]);

    a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_count == '0 && !post_vld) |=> (pending & ~$past(pending)) == '0);

    a_r9_irq_gating: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> irq_req == ($past(gie && !err_lvl && !exc_lvl)
                              && (($past(mask) & pending) != '0)));

    a_r10_any_pend: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend == ((pending != '0) || hit_c));
endmodule

bind irq_pending_gate irq_pending_chk #(
    .LINES(LINES), .LINE_W(LINE_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_line(post_line),
    .clr_vld(clr_vld), .clr_line(clr_line), .clr_all(clr_all), .gie(gie),
    .err_lvl(err_lvl), .exc_lvl(exc_lvl), .mask(mask), .tmr_count(tmr_count),
    .tmr_compare(tmr_compare), .tmr_sel(tmr_sel), .pending(pending),
    .irq_req(irq_req), .any_pend(any_pend), .line_err(line_err)
);

// File: tb/sim_irq_pending_gate.sv
module sim_irq_pending_gate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_vld = 0, clr_vld = 0, clr_all = 0;
    logic [3:0]  post_line = 0, clr_line = 0;
    logic        gie = 0, err_lvl = 0, exc_lvl = 0;
    logic [7:0]  mask = 0;
    logic [31:0] tmr_count = 0, tmr_compare = 1;
    logic [2:0]  tmr_sel = 0;
    logic [7:0]  pending;
    logic        irq_req, any_pend, line_err;

    int total = 0, bad = 0;
    logic [7:0] m_pend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pending_gate u0 (
        .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_line(post_line),
        .clr_vld(clr_vld), .clr_line(clr_line), .clr_all(clr_all), .gie(gie),
        .err_lvl(err_lvl), .exc_lvl(exc_lvl), .mask(mask), .tmr_count(tmr_count),
        .tmr_compare(tmr_compare), .tmr_sel(tmr_sel), .pending(pending),
        .irq_req(irq_req), .any_pend(any_pend), .line_err(line_err));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        post_vld = 0; clr_vld = 0; clr_all = 0;
        tmr_count = 0; tmr_compare = 1;
    endtask

    // One cycle: inputs already applied after a falling edge.
    task automatic tick(string req);
        logic       hit;
        logic [7:0] nxt;
        logic       e_err, e_irq;
        hit = (tmr_count == tmr_compare) && (tmr_count != 0);
        nxt = clr_all ? 8'h00 : m_pend;
        if (clr_vld && clr_line < 8) nxt[clr_line[2:0]] = 1'b0;
        if (post_vld && post_line < 8) nxt[post_line[2:0]] = 1'b1;
        if (hit) nxt[tmr_sel] = 1'b1;
        e_err = (post_vld && post_line >= 8) || (clr_vld && clr_line >= 8);
        e_irq = gie && !err_lvl && !exc_lvl && ((mask & nxt) != 0);
        #1;
        check({req, "/R10 any_pend"}, 32'(any_pend), 32'((m_pend != 0) || hit));
        @(posedge clk); #1;
        check({req, " pending"}, 32'(pending), 32'(nxt));
        check({req, "/R5 line_err"}, 32'(line_err), 32'(e_err));
        check({req, "/R9 irq_req"}, 32'(irq_req), 32'(e_irq));
        m_pend = nxt;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state, with a post held during reset
        post_vld = 1; post_line = 4'd2;
        repeat (3) @(posedge clk);
        #1;
        check("R1 pending", 32'(pending), 0);
        check("R1 irq_req", 32'(irq_req), 0);
        check("R1 line_err", 32'(line_err), 0);
        @(negedge clk);
        rst_n = 1; idle();
        gie = 1; mask = 8'hFF;

        // R2 / R3: post and clear every line, legal and illegal (R5)
        for (int n = 0; n < 16; n++) begin
            post_vld = 1; post_line = 4'(n); tick("R2 post"); idle();
        end
        for (int n = 0; n < 16; n++) begin
            clr_vld = 1; clr_line = 4'(n); tick("R3 clear"); idle();
        end
        check("R3 all cleared", 32'(pending), 0);

        // R5: illegal lines leave a nonzero vector alone
        post_vld = 1; post_line = 4'd5; tick("R2 setup"); idle();
        post_vld = 1; post_line = 4'd12; tick("R5 bad post"); idle();
        clr_vld = 1; clr_line = 4'd8; tick("R5 bad clear"); idle();
        check("R5 bit kept", 32'(pending), 32'h20);
        tick("R5 flag drops");

        // R4: clear-all
        post_vld = 1; post_line = 4'd0; tick("R2 setup"); idle();
        clr_all = 1; tick("R4 clear all"); idle();
        check("R4 zero", 32'(pending), 0);

        // R6: timer match for every select value
        for (int s = 0; s < 8; s++) begin
            tmr_sel = 3'(s); tmr_count = 32'(100 + s); tmr_compare = 32'(100 + s);
            tick("R6 timer"); idle();
            clr_all = 1; tick("R4 wipe"); idle();
        end

        // R7: equal at count zero is ignored
        tmr_count = 0; tmr_compare = 0; tmr_sel = 3'd3;
        tick("R7 zero count"); idle();
        check("R7 none set", 32'(pending), 0);
        // non-equal values
        tmr_count = 5; tmr_compare = 6; tick("R6 no match"); idle();

        // R8: priority
        post_vld = 1; post_line = 4'd4; clr_vld = 1; clr_line = 4'd4;
        tick("R8 post vs clear"); idle();
        check("R8 post wins", 32'(pending), 32'h10);
        tmr_sel = 3'd4; tmr_count = 9; tmr_compare = 9; clr_vld = 1; clr_line = 4'd4;
        tick("R8 timer vs clear"); idle();
        tmr_sel = 3'd1; tmr_count = 9; tmr_compare = 9; clr_all = 1;
        tick("R8 timer vs clear all"); idle();
        check("R8 timer kept", 32'(pending), 32'h02);
        post_vld = 1; post_line = 4'd6; clr_all = 1;
        tick("R8 post vs clear all"); idle();

        // R9: sweep gate bits and masks over a fixed pending vector
        post_vld = 1; post_line = 4'd3; tick("R2 setup"); idle();
        for (int g = 0; g < 8; g++) begin
            for (int m = 0; m < 256; m += 17) begin
                gie = g[0]; err_lvl = g[1]; exc_lvl = g[2]; mask = 8'(m);
                tick("R9 gate");
            end
        end
        gie = 0; mask = 0;
        tick("R10 disabled any");
        tmr_count = 77; tmr_compare = 77; tmr_sel = 3'd7;
        clr_all = 1; tick("R10 timer any"); idle();

        // R1: reset clears a nonzero vector
        gie = 1; mask = 8'hFF;
        post_vld = 1; post_line = 4'd1; tick("R2 setup"); idle();
        rst_n = 0; @(posedge clk); #1;
        check("R1 reset clears", 32'(pending), 0);
        check("R1 irq low", 32'(irq_req), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule